// File: doc/BRIEF.md
# Slow-Domain Power Sequencer

This block is the always-on half of a chip's power controller. It runs from a slow, always-available clock and walks the main power domain and the peripheral clocks through power-down and power-up. Going down, it drops its wake request to the fast-domain sequencer and waits for the fast side to let go. It then raises the isolation clamps and sets each clock enable from the low-power control bits. It waits for every disabled clock to report that it has stopped, and finally sets the main supply control from a control bit.

Going up, on reset or on a wake event, it turns the main supply on and waits for the supply-good indication. It then raises the clock enables, using the active-mode bit for each clock that has one; all other clocks are forced on. It waits for every enabled clock to report valid, releases the clamps, and only then asks the fast domain to wake.

All acknowledge inputs from the analog side and from the fast domain pass through a synchronizer before the state machine sees them. The clock set is a parameter. Clock index 0 is core, 1 is IO and 2 is USB, and a mask parameter picks which clocks follow an active-mode bit (USB by default).

Top module: `slow_pwr_seq`

## Requirements
- R1: While reset is held, clk_en_o is all zeros, main_pd_n_o is 0, clamp_en_o is 1, clamp_o is 1 and pwrup_req_o is 0.
- R2: After reset and after each wake, main_pd_n_o goes to 1 before any clock enable is raised, and it stays 1 while pwrup_req_o is asserted.
- R3: When pwrup_req_o rises, every clock outside ACT_CTRL_MASK is enabled whatever its ctrl_act_clk_en_i bit is. Each clock inside the mask (by default bit 2, USB) equals its ctrl_act_clk_en_i bit.
- R4: pwrup_req_o is not raised while any enabled clock has its clk_val_i low; it rises once all of them are high.
- R5: While main_pok_i stays low in the power-up sequence, the clock enables are not changed and pwrup_req_o stays 0.
- R6: lp_req_i is acted on only while the sequencer is idle with pwrup_req_o high. The sequencer then drops pwrup_req_o and does not raise the clamps until fast_ack_i is low.
- R7: When clamp_o rises during power-down, clk_en_o equals ctrl_lp_clk_en_i, and clamp_en_o rose exactly one cycle earlier.
- R8: main_pd_n_o takes the ctrl_main_pd_n_i value only after every disabled clock has its clk_val_i low.
- R9: clamp_o never changes unless clamp_en_o already holds the new value from the previous cycle. Raising the clamp is therefore preceded by clamp_en_o rising, and releasing it is preceded by clamp_en_o falling.
- R10: wake_i starts a power-up only in the low-power state and has no effect while the sequencer is idle. On power-up, clamp_en_o falls one cycle before clamp_o falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on slow clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_lp_clk_en_i | input | NUM_CLKS | Per-clock enable to apply on power-down |
| ctrl_act_clk_en_i | input | NUM_CLKS | Per-clock enable on power-up; only bits in ACT_CTRL_MASK are used |
| ctrl_main_pd_n_i | input | 1 | Main supply control to apply on power-down (0 = off) |
| lp_req_i | input | 1 | Request to enter low power, from the fast domain |
| wake_i | input | 1 | Wake event while in low power |
| fast_ack_i | input | 1 | Fast-domain handshake acknowledge (asynchronous) |
| clk_val_i | input | NUM_CLKS | Per-clock running indication (asynchronous) |
| main_pok_i | input | 1 | Main supply good (asynchronous) |
| clk_en_o | output | NUM_CLKS | Clock enables, bit 0 core, 1 IO, 2 USB |
| main_pd_n_o | output | 1 | Main supply control, active-low power-down |
| clamp_en_o | output | 1 | Clamp preparation (leads clamp_o) |
| clamp_o | output | 1 | Isolation clamp |
| pwrup_req_o | output | 1 | Wake request to the fast-domain sequencer |

## Verification
Repeated power-down and wake round trips use random low-power clock masks, random active-mode bits and a random supply bit. These show whether each enable is taken from the right control field at the right point: the low-power set at clamp time and the active set at the wake request. Directed cases hold one clock's valid low on the way up, or hold a disabled clock's valid high on the way down. They also hold the supply-good input low after reset and pulse wake_i while idle. Each of these separates a sequencer that truly waits on its acknowledgement from one that moves on by itself. A running monitor times every clamp edge against the clamp-enable edge.

// File: rtl/slow_pwr_pkg.sv
package slow_pwr_pkg;

    typedef enum logic [3:0] {
        SEQ_RESET     = 4'd0,
        SEQ_LOWPWR    = 4'd1,
        SEQ_MAIN_ON   = 4'd2,
        SEQ_CLK_ON    = 4'd3,
        SEQ_REL_CLAMP = 4'd4,
        SEQ_REQ_UP    = 4'd5,
        SEQ_IDLE      = 4'd6,
        SEQ_ACK_DOWN  = 4'd7,
        SEQ_CLAMP_ON  = 4'd8,
        SEQ_CLK_OFF   = 4'd9,
        SEQ_MAIN_OFF  = 4'd10
    } seq_state_e;

endpackage

// File: rtl/slow_pwr_sync.sv
module slow_pwr_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int k = 0; k < STAGES; k++) begin
                stage_q[k] <= '0;
            end
        end else begin
            stage_q[0] <= async_i;
            for (int k = 1; k < STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/slow_pwr_clk_sel.sv
module slow_pwr_clk_sel #(
    parameter int                NUM_CLKS      = 3,
    parameter logic [NUM_CLKS-1:0] ACT_CTRL_MASK = 3'b100
) (
    input  logic [NUM_CLKS-1:0] ctrl_act_i,
    input  logic [NUM_CLKS-1:0] clk_en_i,
    input  logic [NUM_CLKS-1:0] clk_val_i,
    output logic [NUM_CLKS-1:0] act_vec_o,
    output logic                all_up_o,
    output logic                all_down_o
);
    logic [NUM_CLKS-1:0] up_ok;
    logic [NUM_CLKS-1:0] down_ok;

    for (genvar g = 0; g < NUM_CLKS; g++) begin : g_clk
        // Clocks outside the mask are forced on when active.
        assign act_vec_o[g] = ctrl_act_i[g] | ~ACT_CTRL_MASK[g];
        // An enabled clock must report valid; a disabled one must report stopped.
        assign up_ok[g]     = clk_val_i[g] | ~clk_en_i[g];
        assign down_ok[g]   = ~clk_val_i[g] | clk_en_i[g];
    end

    assign all_up_o   = &up_ok;
    assign all_down_o = &down_ok;
endmodule

// File: rtl/slow_pwr_seq.sv
module slow_pwr_seq
    import slow_pwr_pkg::*;
#(
    parameter int                  NUM_CLKS      = 3,
    parameter logic [NUM_CLKS-1:0] ACT_CTRL_MASK = 3'b100,
    parameter int                  SYNC_STAGES   = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_CLKS-1:0] ctrl_lp_clk_en_i,
    input  logic [NUM_CLKS-1:0] ctrl_act_clk_en_i,
    input  logic                ctrl_main_pd_n_i,
    input  logic                lp_req_i,
    input  logic                wake_i,
    input  logic                fast_ack_i,
    input  logic [NUM_CLKS-1:0] clk_val_i,
    input  logic                main_pok_i,
    output logic [NUM_CLKS-1:0] clk_en_o,
    output logic                main_pd_n_o,
    output logic                clamp_en_o,
    output logic                clamp_o,
    output logic                pwrup_req_o
);
    localparam int SYNC_W = NUM_CLKS + 2;

    typedef struct packed {
        seq_state_e          st;
        logic [NUM_CLKS-1:0] clk_en;
        logic                main_pd_n;
        logic                clamp_en;
        logic                clamp;
        logic                req;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic [SYNC_W-1:0]   sync_out;
    logic [NUM_CLKS-1:0] val_s;
    logic                pok_s;
    logic                ack_s;
    logic [NUM_CLKS-1:0] act_vec;
    logic                clks_up;
    logic                clks_down;

    slow_pwr_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({clk_val_i, main_pok_i, fast_ack_i}),
        .sync_o  (sync_out)
    );

    assign val_s = sync_out[SYNC_W-1:2];
    assign pok_s = sync_out[1];
    assign ack_s = sync_out[0];

    slow_pwr_clk_sel #(
        .NUM_CLKS      (NUM_CLKS),
        .ACT_CTRL_MASK (ACT_CTRL_MASK)
    ) u_clk_sel (
        .ctrl_act_i (ctrl_act_clk_en_i),
        .clk_en_i   (seq_q.clk_en),
        .clk_val_i  (val_s),
        .act_vec_o  (act_vec),
        .all_up_o   (clks_up),
        .all_down_o (clks_down)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            SEQ_RESET: begin
                seq_d.st        = SEQ_MAIN_ON;
                seq_d.main_pd_n = 1'b1;
            end
            SEQ_LOWPWR: begin
                if (wake_i) begin
                    seq_d.st        = SEQ_MAIN_ON;
                    seq_d.main_pd_n = 1'b1;
                end
            end
            SEQ_MAIN_ON: begin
                if (pok_s) begin
                    seq_d.st     = SEQ_CLK_ON;
                    seq_d.clk_en = act_vec;
                end
            end
            SEQ_CLK_ON: begin
                if (clks_up) begin
                    seq_d.st       = SEQ_REL_CLAMP;
                    seq_d.clamp_en = 1'b0;
                end
            end
            SEQ_REL_CLAMP: begin
                seq_d.st    = SEQ_REQ_UP;
                seq_d.clamp = 1'b0;
                seq_d.req   = 1'b1;
            end
            SEQ_REQ_UP: begin
                if (ack_s) begin
                    seq_d.st = SEQ_IDLE;
                end
            end
            SEQ_IDLE: begin
                if (lp_req_i) begin
                    seq_d.st  = SEQ_ACK_DOWN;
                    seq_d.req = 1'b0;
                end
            end
            SEQ_ACK_DOWN: begin
                if (!ack_s) begin
                    seq_d.st       = SEQ_CLAMP_ON;
                    seq_d.clamp_en = 1'b1;
                    seq_d.clk_en   = ctrl_lp_clk_en_i;
                end
            end
            SEQ_CLAMP_ON: begin
                seq_d.st    = SEQ_CLK_OFF;
                seq_d.clamp = 1'b1;
            end
            SEQ_CLK_OFF: begin
                if (clks_down) begin
                    seq_d.st        = SEQ_MAIN_OFF;
                    seq_d.main_pd_n = ctrl_main_pd_n_i;
                end
            end
            SEQ_MAIN_OFF: begin
                if (pok_s == seq_q.main_pd_n) begin
                    seq_d.st = SEQ_LOWPWR;
                end
            end
            default: begin
                seq_d.st = SEQ_RESET;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q.st        <= SEQ_RESET;
            seq_q.clk_en    <= '0;
            seq_q.main_pd_n <= 1'b0;
            seq_q.clamp_en  <= 1'b1;
            seq_q.clamp     <= 1'b1;
            seq_q.req       <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign clk_en_o    = seq_q.clk_en;
    assign main_pd_n_o = seq_q.main_pd_n;
    assign clamp_en_o  = seq_q.clamp_en;
    assign clamp_o     = seq_q.clamp;
    assign pwrup_req_o = seq_q.req;

    AST_CLAMP_SET_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(clamp_o) |-> ($past(clamp_en_o) && clamp_en_o)); // R9
    AST_CLAMP_CLR_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(clamp_o) |-> (!$past(clamp_en_o) && !clamp_en_o)); // R10
    AST_REQ_CLKS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pwrup_req_o) |-> ((clk_en_o | ACT_CTRL_MASK) == {NUM_CLKS{1'b1}})); // R3
    AST_REQ_SUPPLY_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwrup_req_o |-> (main_pd_n_o && !clamp_o)); // R2
    AST_POK_GATES_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.st == SEQ_MAIN_ON && !pok_s) |=> ($stable(clk_en_o) && !pwrup_req_o)); // R5
    AST_ACK_GATES_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.st == SEQ_ACK_DOWN && ack_s) |=> $stable(clamp_en_o)); // R6
    AST_LP_ENABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(clamp_en_o) |-> (clk_en_o == $past(ctrl_lp_clk_en_i))); // R7
endmodule

// File: tb/slow_pwr_seq_test.sv
module slow_pwr_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 3;
    localparam logic [N-1:0] MASK = 3'b100;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] ctrl_lp = '0;
    logic [N-1:0] ctrl_act = '0;
    logic         ctrl_pd_n = 1'b1;
    logic         lp_req = 1'b0;
    logic         wake = 1'b0;
    logic         fast_ack = 1'b0;
    logic [N-1:0] clk_val = '0;
    logic         pok = 1'b0;
    logic [N-1:0] clk_en;
    logic         pd_n, clamp_en, clamp, req;

    logic [N-1:0] hold_lo = '0;
    logic [N-1:0] force_hi = '0;
    logic         pok_hold = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int clamp_viol = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slow_pwr_seq #(.NUM_CLKS(N), .ACT_CTRL_MASK(MASK), .SYNC_STAGES(2)) uut (
        .clk_i(clk), .rst_ni(rst_n),
        .ctrl_lp_clk_en_i(ctrl_lp), .ctrl_act_clk_en_i(ctrl_act),
        .ctrl_main_pd_n_i(ctrl_pd_n), .lp_req_i(lp_req), .wake_i(wake),
        .fast_ack_i(fast_ack), .clk_val_i(clk_val), .main_pok_i(pok),
        .clk_en_o(clk_en), .main_pd_n_o(pd_n), .clamp_en_o(clamp_en),
        .clamp_o(clamp), .pwrup_req_o(req)
    );

    function automatic logic [N-1:0] exp_up(input logic [N-1:0] act);
        return act | ~MASK;
    endfunction

    task automatic chk(input bit ok, input string rq,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic wait_req(input logic v, input string rq);
        int t = 0;
        while (req !== v && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(req === v, rq, 32'(req), 32'(v));
    endtask

    task automatic wait_clamp(input string rq);
        int t = 0;
        while (clamp !== 1'b1 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(clamp === 1'b1, rq, 32'(clamp), 32'd1);
    endtask

    // Analog / fast-side responders, driven away from the active edge.
    initial begin
        int cnt [N];
        int pcnt = 0;
        logic [1:0] ack_sh = '0;
        for (int i = 0; i < N; i++) cnt[i] = 0;
        forever begin
            @(negedge clk);
            cyc++;
            for (int i = 0; i < N; i++) begin
                if (force_hi[i]) clk_val[i] = 1'b1;
                else if (!clk_en[i] || hold_lo[i]) begin
                    clk_val[i] = 1'b0;
                    cnt[i] = 0;
                end else if (cnt[i] >= 2 + i) clk_val[i] = 1'b1;
                else cnt[i]++;
            end
            if (!pd_n || pok_hold) begin
                pok = 1'b0;
                pcnt = 0;
            end else if (pcnt >= 3) pok = 1'b1;
            else pcnt++;
            fast_ack = ack_sh[1];
            ack_sh = {ack_sh[0], req};
        end
    end

    // Clamp ordering monitor (R9, R7 one-cycle lead, R10 one-cycle lead).
    initial begin
        logic p_clamp = 1'b1, p_en = 1'b1;
        int en_chg = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (clamp_en !== p_en) en_chg = cyc;
                if (clamp !== p_clamp) begin
                    if (clamp !== p_en || (cyc - en_chg) != 1) clamp_viol++;
                end
            end
            p_clamp = clamp;
            p_en = clamp_en;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic power_down(input logic [N-1:0] lp, input logic pd);
        ctrl_lp = lp;
        ctrl_pd_n = pd;
        @(negedge clk);
        lp_req = 1'b1;
        wait_req(1'b0, "R6 request drop");
        lp_req = 1'b0;
        wait_clamp("R7 clamp raise");
        chk(clk_en === lp, "R7 lp enables at clamp", 32'(clk_en), 32'(lp));
        chk(clamp_en === 1'b1, "R7 clamp_en held", 32'(clamp_en), 32'd1);
    endtask

    task automatic wake_up(input logic [N-1:0] act);
        ctrl_act = act;
        @(negedge clk);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h51A7E));
        ctrl_act = 3'b011;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(clk_en === '0, "R1 clk_en", 32'(clk_en), 32'd0);
        chk({pd_n, clamp_en, clamp, req} === 4'b0110, "R1 controls",
            32'({pd_n, clamp_en, clamp, req}), 32'b0110);

        // R5: supply-good held low after reset
        pok_hold = 1'b1;
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        chk(pd_n === 1'b1, "R2 supply on first", 32'(pd_n), 32'd1);
        chk(clk_en === '0, "R5 enables wait for pok", 32'(clk_en), 32'd0);
        chk(req === 1'b0, "R5 no request", 32'(req), 32'd0);
        pok_hold = 1'b0;
        wait_req(1'b1, "R4 request after clocks");
        chk(clk_en === exp_up(3'b011), "R3 usb active bit low", 32'(clk_en), 32'(exp_up(3'b011)));
        chk({clamp_en, clamp} === 2'b00, "R10 clamps released", 32'({clamp_en, clamp}), 32'd0);

        // R10: wake ignored while idle
        repeat (5) @(negedge clk);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        repeat (10) @(negedge clk);
        chk(req === 1'b1 && clamp_en === 1'b0, "R10 wake ignored in idle",
            32'({req, clamp_en}), 32'b10);

        // R8: disabled clock still reporting valid blocks supply-off
        force_hi[1] = 1'b1;
        power_down(3'b001, 1'b0);
        repeat (30) @(negedge clk);
        chk(pd_n === 1'b1, "R8 supply held while clock runs", 32'(pd_n), 32'd1);
        force_hi[1] = 1'b0;
        repeat (30) @(negedge clk);
        chk(pd_n === 1'b0, "R8 supply follows ctrl", 32'(pd_n), 32'd0);

        // R4: an enabled clock's valid held low blocks the request
        hold_lo[0] = 1'b1;
        wake_up(3'b100);
        repeat (40) @(negedge clk);
        chk(req === 1'b0, "R4 request blocked", 32'(req), 32'd0);
        chk(clk_en[0] === 1'b1, "R4 core enabled while waiting", 32'(clk_en[0]), 32'd1);
        hold_lo[0] = 1'b0;
        wait_req(1'b1, "R4 request after release");
        chk(clk_en === exp_up(3'b100), "R3 enables at request", 32'(clk_en), 32'(exp_up(3'b100)));
        chk(pd_n === 1'b1, "R2 supply on at request", 32'(pd_n), 32'd1);

        // Random round trips
        for (int it = 0; it < 10; it++) begin
            logic [N-1:0] lp = N'($urandom);
            logic         pd = 1'($urandom);
            logic [N-1:0] act = N'($urandom);
            repeat (1 + $urandom % 5) @(negedge clk);
            power_down(lp, pd);
            repeat (40) @(negedge clk);
            chk(pd_n === pd, "R8 supply bit", 32'(pd_n), 32'(pd));
            chk(req === 1'b0, "R6 no request in low power", 32'(req), 32'd0);
            wake_up(act);
            wait_req(1'b1, "R10 wake restarts");
            chk(clk_en === exp_up(act), "R3 active enables", 32'(clk_en), 32'(exp_up(act)));
        end

        chk(clamp_viol == 0, "R9 clamp edge ordering", 32'(clamp_viol), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule